// File: doc/BRIEF.md
# DDS Initialization Command Sequencer

This block sits on the host side of a serially programmed direct digital synthesizer. It brings the synthesizer from power-up to a single steady tone. One accepted request carries a 28-bit tuning word. The block then sends a fixed series of five 16-bit command words over a three-wire link: an active-low frame strobe, a serial clock and serial data.

The series runs in this order:

1. It puts the synthesizer into reset and enables two-write loading of the tuning word.
2. It writes the low 14 bits of the tuning word.
3. It writes the high 14 bits of the tuning word.
4. It writes the phase-0 offset.
5. It releases reset.

Reset is released last, so the output starts only after every register holds a known value. Working out the tuning word from a target frequency is left to the requester.

The request side is a valid/ready stream. A request is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. The tuning word is captured on that cycle. `cmd_ready` stays low from acceptance until the done pulse, and a valid presented during that time is not taken. The block has no storage for pending requests. A requester that wants a second run must hold `cmd_valid` until `cmd_ready` returns. `seq_done` is a plain one-cycle status pulse.

Top module: `dds_init_seq`

## Requirements
- R1: An accepted request produces exactly five frames. The first frame carries 0x2100: bit 13 enables two-write loading and bit 8 holds the synthesizer in reset.
- R2: The second frame carries 01 in bits 15:14 and bits 13:0 of the tuning word in bits 13:0.
- R3: The third frame carries 01 in bits 15:14 and bits 27:14 of the tuning word in bits 13:0.
- R4: The fourth frame carries 110 in bits 15:13 and 0 in bit 12. Bits 11:0 hold the parameter `PHASE0` (default 0, which gives 0xC000).
- R5: The fifth and last frame carries 0x2000: bit 13 stays set and the reset bit is cleared.
- R6: Each frame holds `frame_n` low for exactly 16 falling edges of `ser_clk`, and the data goes most significant bit first.
- R7: `ser_clk` idles high whenever `frame_n` is high. Inside a frame, `ser_data` changes only together with a rising edge of `ser_clk`, so it is stable at each falling edge.
- R8: Between frames, `frame_n` stays high for at least one full `ser_clk` period (2·`SCLK_HALF` clock cycles).
- R9: `seq_done` pulses high for exactly one cycle after the fifth frame has closed. The frame strobe is high at that moment.
- R10: `cmd_ready` is low from acceptance until after `seq_done`. A valid presented while it is low starts no new frames and changes no word of the running series.
- R11: After reset, `frame_n` is 1, `ser_clk` is 1, `ser_data` is 0, `seq_done` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Request ready; high only while idle |
| cmd_freq | input | 28 | Tuning word, captured at handshake |
| frame_n | output | 1 | Active-low frame strobe |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_data | output | 1 | Serial data, MSB first |
| seq_done | output | 1 | One-cycle pulse after the last frame |

## Verification
Some properties are checked on every cycle by the assertions:
- the serial clock stays high outside frames;
- data moves only with a rising serial clock inside a frame;
- the idle gap between frames is long enough;
- the done pulse lasts one cycle, with the strobe high;
- readiness drops right after a handshake.

Other behaviour only the bench scenarios can show:
- the content and order of the five words for each tuning word, including the split of the word into two halves;
- the count of exactly sixteen bits per frame;
- the fact that a request made during a running series leaves it untouched.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;
  localparam int WORD_W   = 16;
  localparam int N_WORDS  = 5;
  localparam logic [15:0] CTRL_HOLD = 16'h2100; // two-write load + reset
  localparam logic [15:0] CTRL_RUN  = 16'h2000; // two-write load, reset cleared
  localparam logic [1:0]  ADDR_F0   = 2'b01;
  localparam logic [2:0]  ADDR_P0   = 3'b110;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_SEND = 2'd1,
    SH_GAP  = 2'd2
  } shift_state_t;
endpackage

// File: rtl/dds_cmd_word.sv
module dds_cmd_word
  import dds_seq_pkg::*;
#(
  parameter int FW = 28,
  parameter int PW = 12,
  parameter logic [PW-1:0] PHASE0 = '0
) (
  input  logic [2:0]    idx,
  input  logic [FW-1:0] freq,
  output logic [15:0]   word
);
  localparam int HW = FW / 2;

  always_comb begin
    case (idx)
      3'd0:    word = CTRL_HOLD;
      3'd1:    word = {ADDR_F0, freq[HW-1:0]};
      3'd2:    word = {ADDR_F0, freq[FW-1:HW]};
      3'd3:    word = {ADDR_P0, 1'b0, PHASE0};
      default: word = CTRL_RUN;
    endcase
  end
endmodule

// File: rtl/dds_ser_shift.sv
module dds_ser_shift
  import dds_seq_pkg::*;
#(
  parameter int W    = 16,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         idle,
  output logic         word_done,
  output logic         frame_n,
  output logic         ser_clk,
  output logic         ser_data
);
  localparam int HCW = $clog2(HALF) + 1;
  localparam int BCW = $clog2(W);
  localparam int GCW = $clog2(2 * HALF + 1) + 1;

  shift_state_t   st;
  logic [HCW-1:0] hcnt;
  logic [BCW-1:0] bcnt;
  logic [W-1:0]   sh;
  logic           gap_second;
  logic           tick;

  assign tick = (hcnt == HCW'(HALF - 1));
  assign idle = (st == SH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SH_IDLE;
      hcnt       <= '0;
      bcnt       <= '0;
      sh         <= '0;
      gap_second <= 1'b0;
      word_done  <= 1'b0;
      frame_n    <= 1'b1;
      ser_clk    <= 1'b1;
      ser_data   <= 1'b0;
    end else begin
      word_done <= 1'b0;
      case (st)
        SH_IDLE: begin
          hcnt <= '0;
          if (load) begin
            sh       <= word;
            ser_data <= word[W-1];
            frame_n  <= 1'b0;
            ser_clk  <= 1'b1;
            bcnt     <= '0;
            st       <= SH_SEND;
          end
        end
        SH_SEND: begin
          if (tick) begin
            hcnt <= '0;
            if (ser_clk) begin
              ser_clk <= 1'b0;
            end else begin
              ser_clk <= 1'b1;
              if (bcnt == BCW'(W - 1)) begin
                frame_n    <= 1'b1;
                ser_data   <= 1'b0;
                gap_second <= 1'b0;
                st         <= SH_GAP;
              end else begin
                sh       <= sh << 1;
                ser_data <= sh[W-2];
                bcnt     <= bcnt + 1'b1;
              end
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        SH_GAP: begin
          if (tick) begin
            hcnt <= '0;
            if (gap_second) begin
              st        <= SH_IDLE;
              word_done <= 1'b1;
            end else begin
              gap_second <= 1'b1;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  // Assertion support: strobe-high cycle count since the last frame
  logic [GCW-1:0] hi_cnt;
  logic           seen_frame;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt     <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (!frame_n) seen_frame <= 1'b1;
      if (!frame_n) hi_cnt <= '0;
      else if (hi_cnt < GCW'(2 * HALF)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  p_clk_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |-> ser_clk);
  p_data_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && $past(!frame_n) && ser_data != $past(ser_data)) |-> $rose(ser_clk));
  p_frame_ends_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> ser_clk);
  p_gap_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && seen_frame) |-> (hi_cnt >= GCW'(2 * HALF)));
endmodule

// File: rtl/dds_init_seq.sv
module dds_init_seq
  import dds_seq_pkg::*;
#(
  parameter int FW = 28,
  parameter int PW = 12,
  parameter logic [PW-1:0] PHASE0 = '0,
  parameter int SCLK_HALF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [FW-1:0] cmd_freq,
  output logic          frame_n,
  output logic          ser_clk,
  output logic          ser_data,
  output logic          seq_done
);
  logic          busy;
  logic [2:0]    idx;
  logic [FW-1:0] freq_q;
  logic          load_q;
  logic [15:0]   cur_word;
  logic          sh_idle;
  logic          sh_done;
  logic          accept;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  dds_cmd_word #(.FW(FW), .PW(PW), .PHASE0(PHASE0)) u_word (
    .idx  (idx),
    .freq (freq_q),
    .word (cur_word)
  );

  dds_ser_shift #(.W(WORD_W), .HALF(SCLK_HALF)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_q),
    .word      (cur_word),
    .idle      (sh_idle),
    .word_done (sh_done),
    .frame_n   (frame_n),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      freq_q   <= '0;
      load_q   <= 1'b0;
      seq_done <= 1'b0;
    end else begin
      load_q   <= 1'b0;
      seq_done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        freq_q <= cmd_freq;
        idx    <= '0;
        load_q <= 1'b1;
      end else if (busy && sh_done) begin
        if (idx == 3'(N_WORDS - 1)) begin
          busy     <= 1'b0;
          seq_done <= 1'b1;
        end else begin
          idx    <= idx + 1'b1;
          load_q <= 1'b1;
        end
      end
    end
  end

  p_load_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> sh_idle);
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);
  p_done_frame_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (frame_n && cmd_ready));
endmodule

// File: tb/sim_dds_init_seq.sv
module sim_dds_init_seq;
  localparam int HALF = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, cmd_valid, cmd_ready, frame_n, ser_clk, ser_data, seq_done;
  logic [27:0] cmd_freq;

  dds_init_seq #(.SCLK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_freq(cmd_freq), .frame_n(frame_n), .ser_clk(ser_clk),
    .ser_data(ser_data), .seq_done(seq_done)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // serial monitor, sampled away from the active edge
  logic [15:0] cap [0:7];
  logic [15:0] shreg;
  int nfr, nbits, bits_bad, edge_bad, gap_bad, hicnt;
  logic pfs = 1'b1, psclk = 1'b1, psd = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      pfs = 1'b1; psclk = 1'b1; psd = 1'b0; nbits = 0; hicnt = 0;
    end else begin
      if (pfs && !frame_n) begin
        if (nfr > 0 && hicnt < 2 * HALF) gap_bad++;
        nbits = 0;
      end
      if (!frame_n && !pfs && ser_data != psd && !(ser_clk && !psclk)) edge_bad++;
      if (frame_n && !ser_clk) edge_bad++;
      if (!frame_n && psclk && !ser_clk) begin
        shreg = {shreg[14:0], ser_data};
        nbits++;
      end
      if (!pfs && frame_n) begin
        if (nfr < 8) cap[nfr] = shreg;
        if (nbits != 16) bits_bad++;
        nfr++;
      end
      hicnt = frame_n ? hicnt + 1 : 0;
      pfs = frame_n; psclk = ser_clk; psd = ser_data;
    end
  end

  task automatic run_seq(input logic [27:0] f, input logic [15:0] exp_lo,
                         input logic [15:0] exp_hi, input bit poke);
    bit got_done = 0;
    nfr = 0; bits_bad = 0; edge_bad = 0; gap_bad = 0;
    @(negedge clk);
    for (int i = 0; i < 100 && !cmd_ready; i++) @(negedge clk);
    cmd_valid = 1'b1; cmd_freq = f;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_freq = 28'h0;
    for (int i = 0; i < 5000; i++) begin
      if (poke && i == 30) begin
        chk(cmd_ready == 1'b0, "R10 ready low while running", 32'(cmd_ready), 32'h0);
        cmd_valid = 1'b1; cmd_freq = 28'h0FFFFFF;
      end
      if (poke && i == 31) begin
        cmd_valid = 1'b0; cmd_freq = 28'h0;
      end
      if (seq_done) begin
        got_done = 1;
        break;
      end
      @(negedge clk);
    end
    chk(got_done, "R9 done seen (watchdog)", 32'(got_done), 32'h1);
    chk(frame_n == 1'b1, "R9 strobe high at done", 32'(frame_n), 32'h1);
    chk(nfr == 5, "R1 frame count", 32'(nfr), 32'd5);
    chk(cap[0] == 16'h2100, "R1 first word", 32'(cap[0]), 32'h2100);
    chk(cap[1] == exp_lo, "R2 low half word", 32'(cap[1]), 32'(exp_lo));
    chk(cap[2] == exp_hi, "R3 high half word", 32'(cap[2]), 32'(exp_hi));
    chk(cap[3] == 16'hC000, "R4 phase word", 32'(cap[3]), 32'hC000);
    chk(cap[4] == 16'h2000, "R5 release word", 32'(cap[4]), 32'h2000);
    chk(bits_bad == 0, "R6 sixteen bits per frame", 32'(bits_bad), 32'h0);
    chk(edge_bad == 0, "R7 data only on rising clock", 32'(edge_bad), 32'h0);
    chk(gap_bad == 0, "R8 gap between frames", 32'(gap_bad), 32'h0);
    @(negedge clk);
    chk(seq_done == 1'b0, "R9 done one cycle", 32'(seq_done), 32'h0);
    chk(cmd_ready == 1'b1, "R10 ready after done", 32'(cmd_ready), 32'h1);
  endtask

  // tuning word, expected low-half frame, expected high-half frame
  localparam logic [59:0] VEC [5] = '{
    {28'h00010C7, 16'h50C7, 16'h4000},
    {28'hFFFFFFF, 16'h7FFF, 16'h7FFF},
    {28'hAAAAAAA, 16'h6AAA, 16'h6AAA},
    {28'h0004000, 16'h4000, 16'h4001},
    {28'h0003FFF, 16'h7FFF, 16'h4000}
  };

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_freq = '0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(frame_n == 1'b1, "R11 strobe idle", 32'(frame_n), 32'h1);
    chk(ser_clk == 1'b1, "R11 clock idle", 32'(ser_clk), 32'h1);
    chk(ser_data == 1'b0, "R11 data idle", 32'(ser_data), 32'h0);
    chk(seq_done == 1'b0, "R11 done idle", 32'(seq_done), 32'h0);
    chk(cmd_ready == 1'b1, "R11 ready idle", 32'(cmd_ready), 32'h1);
    rst_n = 1'b1;

    foreach (VEC[k]) run_seq(VEC[k][59:32], VEC[k][31:16], VEC[k][15:0], 1'b0);

    // R10: request during a running series is not taken
    run_seq(28'h00010C7, 16'h50C7, 16'h4000, 1'b1);
    nfr = 0;
    repeat (400) @(negedge clk);
    chk(nfr == 0, "R10 no frames after ignored request", 32'(nfr), 32'h0);
    chk(frame_n == 1'b1, "R10 strobe stays idle", 32'(frame_n), 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule